// File: doc/BRIEF.md
# Glitch-Free PWM Channel with Power-of-Two and Linear Prescaler

This block produces one pulse-width-modulated pin from two 32-bit configuration words that a register file elsewhere holds. A prescaler divides the source clock by a linear 8-bit stage times a power of two. Each prescaler tick advances an 8-bit period counter. Inside each period, a rising compare point and a falling compare point place the two output edges. The pin stage then applies inversion, a pin gate, an open-drain option and a static-level mode. It presents a data value and an output-enable to the pad.

Timing changes are held in shadow form and take effect when the counter wraps, so a running waveform never shows a period that mixes old and new settings. A control bit can drop that synchronisation, so that writes act on the next clock. A one-cycle strobe marks the start of every period. Nothing in this block moves a stream of data: both configuration words are levels that may change at any cycle. For that reason no port carries a valid/ready handshake and there is no back-pressure.

Top module: `pwmc_channel`

## Requirements
- R1: While reset is held, pad_out, pad_oe and period_start are 0. With both words at zero after reset, pad_out stays 0, pad_oe is 1 and period_start never pulses.
- R2: The period counter advances once every (L+1)·2^E source cycles. L is control bits [7:0] and E is control bits [11:8].
- R3: A period lasts P+1 counter steps, where P is timing bits [31:24]. period_start is a one-cycle pulse, seen in the cycle after the counter wraps from P to 0, so consecutive pulses are (P+1)·(L+1)·2^E cycles apart.
- R4: The rising point is timing bits [7:0] and the falling point is timing bits [15:8]. For counter value c with rising point r and falling point f, the level is high when c ≥ r if f = 0. It is high when r ≤ c < f if 0 < r ≤ f or r = 0. It is high when c ≥ r or c < f if r > f. The pad shows the state of a counter value one cycle later.
- R5: With control bit 16 (clock enable) clear, the counter is held at 0 and the level before inversion is low. Timing written in this state is in force when bit 16 is set again, and the first period_start follows P+1 cycles after re-enable when L = E = 0.
- R6: With control bit 12 (pin enable) clear, the driven level is low whatever the counter and the invert bit show.
- R7: Control bit 14 inverts the driven level on the next clock, mid-period, without waiting for a wrap.
- R8: With control bit 17 clear, a timing write takes effect only at the next wrap, and a write made in the last cycle before a wrap is used by the period that follows. With bit 17 set, a timing write acts on the counter from the next clock.
- R9: With control bit 13 (open drain) set, pad_out is always 0 and pad_oe is 1 exactly when the driven level is low. In push-pull mode pad_oe is 1 and pad_out carries the level.
- R10: With control bit 15 (level mode) set, the counter waveform is ignored and the level equals the invert bit, still gated by pin enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Control word: divider, pin, open-drain, invert, level-mode, clock-enable and sync-disable fields |
| timing_word | input | 32 | Timing word: rising point, falling point and period |
| pad_out | output | 1 | Pad data value |
| pad_oe | output | 1 | Pad output-enable |
| period_start | output | 1 | One-cycle strobe at each period start |

## Verification
The case where two functions meet in one cycle is a timing write that arrives on the last clock before a counter wrap, which is the same edge that loads the shadow values. The bench makes a write in the middle of a period and a second write in the final cycle of that period. It then compares the pad cycle by cycle through a scoreboard. The current period must keep its old falling point. The following period must follow the final write, and the value from the mid-period write must never appear. A companion run with the sync-disable bit set checks that the same kind of mid-period write moves the falling edge within two cycles.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int CNT_W  = 8;
  localparam int DIVL_W = 8;
  localparam int DIVH_W = 4;

  // control word field positions
  localparam int DIVL_LSB   = 0;
  localparam int DIVH_LSB   = 8;
  localparam int PINEN_BIT  = 12;
  localparam int OD_BIT     = 13;
  localparam int INV_BIT    = 14;
  localparam int LVL_BIT    = 15;
  localparam int RUN_BIT    = 16;
  localparam int NOSYNC_BIT = 17;

  // timing word field positions
  localparam int RISE_LSB = 0;
  localparam int FALL_LSB = 8;
  localparam int PER_LSB  = 24;

  typedef struct packed {
    logic              nosync;
    logic              run;
    logic              lvl_mode;
    logic              inv;
    logic              od;
    logic              pin_en;
    logic [DIVH_W-1:0] div_exp;
    logic [DIVL_W-1:0] div_lin;
  } chan_ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] fall;
    logic [CNT_W-1:0] rise;
  } chan_timing_t;
endpackage

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler #(
  parameter int DIVL_W = 8,
  parameter int DIVH_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIVL_W-1:0] div_lin,
  input  logic [DIVH_W-1:0] div_exp,
  output logic              tick
);
  localparam int ACC_W = DIVL_W + (1 << DIVH_W) - 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] term;

  // terminal count = (L+1) * 2^E - 1, modular arithmetic keeps the max case
  always_comb begin
    term = ({{(ACC_W-DIVL_W){1'b0}}, div_lin} + ACC_W'(1)) << div_exp;
    term = term - ACC_W'(1);
  end

  assign tick = run && (acc >= term);

  always_ff @(posedge clk) begin
    if (!rst_n)            acc <= '0;
    else if (!run || tick) acc <= '0;
    else                   acc <= acc + ACC_W'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || term == '0));
endmodule

// File: rtl/pwmc_counter.sv
module pwmc_counter import pwmc_pkg::*; #(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         nosync,
  input  chan_timing_t cfg_in,
  output chan_timing_t act,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = tick && (cnt >= act.period);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= wrap ? '0 : cnt + W'(1);
  end

  // shadow load: at the wrap, every cycle while stopped, or always when sync is off
  always_ff @(posedge clk) begin
    if (!rst_n)                      act <= '0;
    else if (!run || nosync || wrap) act <= cfg_in;
  end

  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !nosync && !wrap) |=> act == $past(act));
endmodule

// File: rtl/pwmc_edge_cmp.sv
module pwmc_edge_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic         high
);
  logic past_rise;
  logic before_fall;

  assign past_rise   = (cnt >= rise);
  assign before_fall = (cnt < fall);

  always_comb begin
    if (fall == '0)        high = past_rise;
    else if (rise <= fall) high = past_rise && before_fall;
    else                   high = past_rise || before_fall;
  end
endmodule

// File: rtl/pwmc_pin_stage.sv
module pwmc_pin_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic high,
  input  logic pin_en,
  input  logic od,
  input  logic inv,
  input  logic lvl_mode,
  output logic pad_out,
  output logic pad_oe
);
  logic level;
  logic drive;

  assign level = lvl_mode ? inv : ((run & high) ^ inv);
  assign drive = pin_en & level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
    end else begin
      pad_out <= od ? 1'b0 : drive;
      pad_oe  <= od ? ~drive : 1'b1;
    end
  end

  // R9
  od_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od |=> !pad_out);

  // R6
  pin_off_pp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_en && !od) |=> (!pad_out && pad_oe));

  // R6
  pin_off_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_en && od) |=> pad_oe);

  // R10
  level_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && pin_en && !od) |=> pad_out == $past(inv));
endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel import pwmc_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ctrl_word,
  input  logic [31:0] timing_word,
  output logic        pad_out,
  output logic        pad_oe,
  output logic        period_start
);
  chan_ctrl_t   c;
  chan_timing_t tw;
  chan_timing_t act;
  logic [CNT_W-1:0] cnt;
  logic tick;
  logic wrap;
  logic high;
  logic unused_fields;

  assign c.div_lin  = ctrl_word[DIVL_LSB +: DIVL_W];
  assign c.div_exp  = ctrl_word[DIVH_LSB +: DIVH_W];
  assign c.pin_en   = ctrl_word[PINEN_BIT];
  assign c.od       = ctrl_word[OD_BIT];
  assign c.inv      = ctrl_word[INV_BIT];
  assign c.lvl_mode = ctrl_word[LVL_BIT];
  assign c.run      = ctrl_word[RUN_BIT];
  assign c.nosync   = ctrl_word[NOSYNC_BIT];

  assign tw.rise   = timing_word[RISE_LSB +: CNT_W];
  assign tw.fall   = timing_word[FALL_LSB +: CNT_W];
  assign tw.period = timing_word[PER_LSB +: CNT_W];

  assign unused_fields = ^{ctrl_word[31:NOSYNC_BIT+1],
                           timing_word[PER_LSB-1:FALL_LSB+CNT_W]};

  pwmc_prescaler #(.DIVL_W(DIVL_W), .DIVH_W(DIVH_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (c.run),
    .div_lin (c.div_lin),
    .div_exp (c.div_exp),
    .tick    (tick)
  );

  pwmc_counter #(.W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (c.run),
    .tick   (tick),
    .nosync (c.nosync),
    .cfg_in (tw),
    .act    (act),
    .cnt    (cnt),
    .wrap   (wrap)
  );

  pwmc_edge_cmp #(.W(CNT_W)) u_cmp (
    .cnt  (cnt),
    .rise (act.rise),
    .fall (act.fall),
    .high (high)
  );

  pwmc_pin_stage u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (c.run),
    .high     (high),
    .pin_en   (c.pin_en),
    .od       (c.od),
    .inv      (c.inv),
    .lvl_mode (c.lvl_mode),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) period_start <= 1'b0;
    else        period_start <= wrap;
  end

  // R3
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_start |-> cnt == '0);

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (period_start && act.period != '0) |=> !period_start);
endmodule

// File: tb/tb_pwmc_channel.sv
module tb_pwmc_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic [31:0] timing_word = '0;
  logic pad_out, pad_oe, period_start;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic  v;
    string tag;
  } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  pwmc_channel dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .timing_word(timing_word),
    .pad_out(pad_out), .pad_oe(pad_oe), .period_start(period_start)
  );

  task automatic check(int act, int exp, string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // control: L[7:0] E[11:8] pin12 od13 inv14 lvl15 run16 nosync17
  function automatic logic [31:0] mk_ctrl(int dl, int dh, bit pin, bit od, bit inv,
                                          bit lvl, bit run, bit nosync);
    logic [31:0] w;
    w = '0;
    w[7:0] = dl[7:0];
    w[11:8] = dh[3:0];
    w[12] = pin; w[13] = od; w[14] = inv; w[15] = lvl; w[16] = run; w[17] = nosync;
    return w;
  endfunction

  // timing: rise[7:0] fall[15:8] period[31:24]
  function automatic logic [31:0] mk_time(int p, int r, int f);
    return {p[7:0], 8'h00, f[7:0], r[7:0]};
  endfunction

  function automatic bit exp_hi(int c, int r, int f);
    if (f == 0) return c >= r;
    if (r <= f) return (c >= r) && (c < f);
    return (c >= r) || (c < f);
  endfunction

  // scoreboard driver side: one full period of expected pad levels
  task automatic push_period(int p, int d, int r, int f, string tag);
    for (int t = 0; t < (p + 1) * d; t++) begin
      item_t it;
      it.v = exp_hi(t / d, r, f);
      it.tag = tag;
      exp_q.push_back(it);
    end
  endtask

  // monitor: one comparison per cycle, after the output register settles
  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check(int'(pad_out), int'(it.v), it.tag);
    end
  end

  task automatic drain();
    int g = 0;
    while (exp_q.size() > 0 && g < 5000) begin
      @(negedge clk);
      g++;
    end
  endtask

  task automatic wait_start();
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!period_start && g < 5000);
  endtask

  task automatic configure(logic [31:0] cw, logic [31:0] tw);
    drain();
    @(negedge clk);
    ctrl_word = cw;
    timing_word = tw;
    wait_start();
  endtask

  task automatic run_period(int p, int dl, int dh, int r, int f, string wtag, string gtag);
    int d = (dl + 1) << dh;
    int n = 0;
    wait_start();
    push_period(p, d, r, f, wtag);
    do begin
      @(negedge clk);
      n++;
    end while (!period_start && n < 5000);
    check(n, (p + 1) * d, gtag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(pad_out, 0, "R1 pad_out in reset");
    check(pad_oe, 0, "R1 pad_oe in reset");
    check(period_start, 0, "R1 strobe in reset");
    rst_n = 1'b1;
    seen = 0;
    repeat (4) begin
      @(negedge clk);
      if (period_start) seen = 1;
    end
    check(pad_out, 0, "R1 pad_out idle");
    check(pad_oe, 1, "R1 pad_oe idle");
    check(seen, 0, "R1 no strobe idle");

    // R4 / R3 basic waveform
    configure(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0), mk_time(7, 0, 3));
    run_period(7, 0, 0, 0, 3, "R4 r0 f3", "R3 gap P7");

    // R2 combined linear and exponent divider
    configure(mk_ctrl(2, 1, 1, 0, 0, 0, 1, 0), mk_time(4, 1, 3));
    run_period(4, 2, 1, 1, 3, "R4 div6", "R2 gap div6");
    configure(mk_ctrl(0, 2, 1, 0, 0, 0, 1, 0), mk_time(2, 0, 1));
    run_period(2, 0, 2, 0, 1, "R4 div4", "R2 gap div4");

    // R4 edge-point corner cases
    configure(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0), mk_time(3, 0, 0));
    run_period(3, 0, 0, 0, 0, "R4 full duty", "R3 gap P3");
    configure(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0), mk_time(5, 2, 0));
    run_period(5, 0, 0, 2, 0, "R4 r2 f0", "R3 gap P5");
    configure(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0), mk_time(7, 5, 2));
    run_period(7, 0, 0, 5, 2, "R4 wrapped pulse", "R3 gap P7b");
    configure(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0), mk_time(5, 3, 3));
    run_period(5, 0, 0, 3, 3, "R4 equal points", "R3 gap P5b");

    // R8 shadowed writes: mid-period ignored, last-cycle write used next
    configure(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0), mk_time(9, 0, 5));
    drain();
    wait_start();
    push_period(9, 1, 0, 5, "R8 old period kept");
    repeat (3) @(negedge clk);
    timing_word = mk_time(9, 0, 7);
    repeat (6) @(negedge clk);
    timing_word = mk_time(9, 0, 2);
    wait_start();
    push_period(9, 1, 0, 2, "R8 last-cycle write");
    drain();

    // R8 sync disabled: mid-period write moves the edge at once
    configure(mk_ctrl(0, 0, 1, 0, 0, 0, 1, 1), mk_time(9, 0, 5));
    wait_start();
    repeat (3) @(negedge clk);
    timing_word = mk_time(9, 0, 2);
    repeat (2) @(negedge clk);
    check(pad_out, 0, "R8 nosync immediate");

    // R5 clock enable off, reprogram, re-enable
    @(negedge clk);
    ctrl_word = mk_ctrl(0, 0, 1, 0, 0, 0, 0, 0);
    timing_word = mk_time(9, 0, 5);
    repeat (2) @(negedge clk);
    check(pad_out, 0, "R5 stopped level");
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (period_start) seen = 1;
    end
    check(seen, 0, "R5 no strobe stopped");
    timing_word = mk_time(5, 0, 0);
    @(negedge clk);
    ctrl_word = mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!period_start && n < 5000);
    check(n, 6, "R5 first strobe after enable");
    check(pad_out, 1, "R5 new duty applied");

    // R7 inversion acts next clock
    repeat (3) @(negedge clk);
    ctrl_word = mk_ctrl(0, 0, 1, 0, 1, 0, 1, 0);
    @(negedge clk);
    check(pad_out, 0, "R7 invert on");
    check(pad_oe, 1, "R9 push-pull oe");
    ctrl_word = mk_ctrl(0, 0, 1, 0, 0, 0, 1, 0);
    @(negedge clk);
    check(pad_out, 1, "R7 invert off");

    // R6 pin disabled
    ctrl_word = mk_ctrl(0, 0, 0, 0, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    check(pad_out, 0, "R6 pin off");
    ctrl_word = mk_ctrl(0, 0, 0, 0, 1, 0, 1, 0);
    repeat (2) @(negedge clk);
    check(pad_out, 0, "R6 pin off inverted");

    // R9 open drain
    ctrl_word = mk_ctrl(0, 0, 1, 1, 0, 0, 1, 0);
    repeat (2) @(negedge clk);
    check(pad_out, 0, "R9 od data");
    check(pad_oe, 0, "R9 od released high");
    ctrl_word = mk_ctrl(0, 0, 1, 1, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    check(pad_oe, 1, "R9 od driving low");
    check(pad_out, 0, "R9 od data low");

    // R10 level mode
    ctrl_word = mk_ctrl(0, 0, 1, 0, 0, 1, 1, 0);
    repeat (2) @(negedge clk);
    check(pad_out, 0, "R10 level low ignores counter");
    ctrl_word = mk_ctrl(0, 0, 1, 0, 1, 1, 1, 0);
    repeat (2) @(negedge clk);
    check(pad_out, 1, "R10 level high");
    ctrl_word = mk_ctrl(0, 0, 1, 0, 1, 1, 0, 0);
    repeat (2) @(negedge clk);
    check(pad_out, 1, "R10 level high stopped");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule